// File: doc/BRIEF.md
# T1/E1 System-Side Frame Timing Formatter

This block produces the transmit-side frame timing of a primary-rate backplane and turns bytes held in an elastic store into the serial system stream. The system side runs either a 193-bit frame (a framing bit, then 24 eight-bit channels) or a 256-bit frame (32 eight-bit channels). A bit counter keeps the frame position. A frame counter keeps the multiframe position, which is 12 frames for the 193-bit layout and 16 frames for the 256-bit layout. A rising edge on the frame-sync input restarts the frame. Without further edges the counters keep running on their own.

For each bit slot the block puts a channel number on `rd_chan`. The store answers with that channel's byte on `rd_byte`, and the block shifts it out most significant bit first. Where the receive and system rates differ, fixed values take the place of missing data. The framing slot is filled from `rx_fbit` only when both sides use the 193-bit layout. Otherwise the block writes a 1 there. A 256-bit system frame fed from a 193-bit receive stream carries all ones in channels 24 to 31. In parallel mode the data runs eight bit times ahead of the frame position, so that an external shift register holds a full channel at the channel boundary. The channel clock and multiframe pulse mark the system-side timing. Storage, slip control and the serial-to-parallel conversion are done elsewhere.

Top module: `tsf_formatter`

## Requirements
- R1: While `rst_n` is low, `ser_out` is 1 and `chan_clk` and `mf_sync` are 0. The frame position and the frame count are both 0.
- R2: The frame position counts 0 to 192 when `sys_rate`=0 and 0 to 255 when `sys_rate`=1, then wraps. A rising edge on `fsync_in` (sampled high, low at the previous clock) makes the next position 0. Without edges the count keeps free-running.
- R3: With `sys_rate`=0, slot 0 is the framing slot. Slot p (1..192) carries bit 7-((p-1) mod 8) of the byte of channel (p-1)/8, with bit 7 sent first. The channel number is shown on `rd_chan`.
- R4: With `sys_rate`=1, slot p (0..255) carries bit 7-(p mod 8) of the byte of channel p/8, with bit 7 sent first.
- R5: With `sys_rate`=0 and `rx_rate`=0, the framing slot carries `rx_fbit`.
- R6: With `sys_rate`=0 and `rx_rate`=1, the framing slot is 1.
- R7: With `sys_rate`=1 and `rx_rate`=0, every bit of channels 24 to 31 (slots 192..255) is 1, whatever `rd_byte` holds.
- R8: When `par_mode`=0, `ser_out` carries the slot equal to the frame position. When `par_mode`=1, it carries the slot (position+8) mod frame length. The output register loads on the rising clock edge together with the position.
- R9: `mf_sync` goes high in the cycle the position enters 0 of frame 0 and stays high for exactly 65 clock cycles. Frame 0 comes round every 12 frames (`sys_rate`=0) or every 16 frames (`sys_rate`=1).
- R10: `chan_clk` is high for the first four bit times of each channel, reckoned from the frame position and not the look-ahead slot. It is low for the other four bit times and during the framing slot, so it rises on every channel boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sys_rate | input | 1 | System rate: 0 = 193-bit frame, 1 = 256-bit frame |
| rx_rate | input | 1 | Receive rate: 0 = 193-bit frame, 1 = 256-bit frame |
| par_mode | input | 1 | 1 = data advanced eight bit times for parallel backplanes |
| fsync_in | input | 1 | System frame sync, rising edge restarts the frame |
| rd_byte | input | 8 | Byte of the requested channel from the store |
| rx_fbit | input | 1 | Framing bit carried through from the receive stream |
| rd_chan | output | 5 | Channel whose byte is being serialised |
| ser_out | output | 1 | Serial system data |
| chan_clk | output | 1 | Channel clock, rising on channel boundaries |
| mf_sync | output | 1 | Multiframe pulse, 65 clocks long |

## Verification
The bench runs all four combinations of receive and system rate in serial mode. Each combination tells apart a different treatment of the framing slot and of the channels above 24: passed through, forced to 1, absent, or filled with ones. Parallel mode is run on both system rates to separate the eight-slot advance from the unshifted channel clock. Runs with a single sync edge check free-running alignment. Runs with a second sync edge placed off the natural boundary show that the frame restarts at once and that the frame count does not step twice. Each run lasts longer than a 16-frame multiframe, so the 65-cycle pulse is seen at both rates.

// File: rtl/tsf_pkg.sv
// Shared definitions for the system-side frame timing formatter.
// Assumes the rate inputs are static between resets.
package tsf_pkg;
    typedef enum logic {
        RATE_193 = 1'b0,
        RATE_256 = 1'b1
    } tsf_rate_e;
endpackage

// File: rtl/tsf_frame_ctr.sv
// Frame bit position and multiframe counter.
// The next state is produced combinationally, so that downstream registers load
// in step with the position. A sync rising edge and the natural wrap both count
// as one frame boundary, never two.
module tsf_frame_ctr
    import tsf_pkg::*;
#(
    parameter int T1_LEN = 193,
    parameter int E1_LEN = 256,
    parameter int T1_MF  = 12,
    parameter int E1_MF  = 16,
    parameter int POS_W  = 9,
    parameter int FRM_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sys_rate,
    input  logic             fsync_in,
    output logic [POS_W-1:0] pos,
    output logic [FRM_W-1:0] frame,
    output logic [POS_W-1:0] nxt_pos,
    output logic [FRM_W-1:0] nxt_frame,
    output logic             mf_entry
);
    localparam logic [POS_W-1:0] T1_LAST = POS_W'(T1_LEN - 1);
    localparam logic [POS_W-1:0] E1_LAST = POS_W'(E1_LEN - 1);
    localparam logic [FRM_W-1:0] T1_MLST = FRM_W'(T1_MF - 1);
    localparam logic [FRM_W-1:0] E1_MLST = FRM_W'(E1_MF - 1);

    logic             fs_q;
    logic             boundary;
    logic [POS_W-1:0] last_pos;
    logic [FRM_W-1:0] last_frm;

    // Work out the next position and frame from the sync edge or the wrap.
    always_comb begin
        last_pos  = (sys_rate == RATE_256) ? E1_LAST : T1_LAST;
        last_frm  = (sys_rate == RATE_256) ? E1_MLST : T1_MLST;
        boundary  = (fsync_in & ~fs_q) | (pos >= last_pos);
        nxt_pos   = boundary ? '0 : pos + 1'b1;
        if (!boundary)
            nxt_frame = frame;
        else if (frame >= last_frm)
            nxt_frame = '0;
        else
            nxt_frame = frame + 1'b1;
        mf_entry  = boundary && (nxt_frame == '0);
    end

    // Hold the sync history, the position and the frame count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_q  <= 1'b0;
            pos   <= '0;
            frame <= '0;
        end else begin
            fs_q  <= fsync_in;
            pos   <= nxt_pos;
            frame <= nxt_frame;
        end
    end
endmodule

// File: rtl/tsf_slot_map.sv
// Maps a frame position to the bit to transmit.
// Applies the parallel-mode look-ahead, picks the channel and the bit within it
// (most significant first), and puts in the fixed values for the framing slot
// and the unfilled channels. Assumes CH_BITS is a power of two.
module tsf_slot_map
    import tsf_pkg::*;
#(
    parameter int T1_LEN    = 193,
    parameter int E1_LEN    = 256,
    parameter int T1_CHANS  = 24,
    parameter int CH_BITS   = 8,
    parameter int LOOKAHEAD = 8,
    parameter int POS_W     = 9,
    parameter int CHN_W     = 5
) (
    input  logic [POS_W-1:0]   slot_pos,
    input  logic               sys_rate,
    input  logic               rx_rate,
    input  logic               par_mode,
    input  logic [CH_BITS-1:0] rd_byte,
    input  logic               rx_fbit,
    output logic [CHN_W-1:0]   rd_chan,
    output logic               bit_val
);
    localparam int BIT_W = $clog2(CH_BITS);
    localparam int CI_W  = POS_W - BIT_W;
    localparam logic [POS_W-1:0] T1_L  = POS_W'(T1_LEN);
    localparam logic [POS_W-1:0] E1_L  = POS_W'(E1_LEN);
    localparam logic [POS_W-1:0] LA    = POS_W'(LOOKAHEAD);
    localparam logic [CI_W-1:0]  T1_CH = CI_W'(T1_CHANS);

    logic [POS_W-1:0] flen;
    logic [POS_W-1:0] look;
    logic [POS_W-1:0] idx;
    logic [CI_W-1:0]  chan;
    logic [BIT_W-1:0] bsel;
    logic             fslot;

    // Pick the transmitted slot, its channel and bit, then apply fills.
    always_comb begin
        flen  = (sys_rate == RATE_256) ? E1_L : T1_L;
        look  = slot_pos + (par_mode ? LA : '0);
        if (look >= flen)
            look = look - flen;
        fslot = (sys_rate == RATE_193) && (look == '0);
        idx   = (sys_rate == RATE_256) ? look : look - 1'b1;
        chan  = idx[POS_W-1:BIT_W];
        bsel  = ~idx[BIT_W-1:0];
        rd_chan = fslot ? '0 : chan[CHN_W-1:0];
        if (fslot)
            bit_val = (rx_rate == RATE_193) ? rx_fbit : 1'b1;
        else if ((sys_rate == RATE_256) && (rx_rate == RATE_193) && (chan >= T1_CH))
            bit_val = 1'b1;
        else
            bit_val = rd_byte[bsel];
    end
endmodule

// File: rtl/tsf_sync_gen.sv
// Channel clock and multiframe pulse.
// The channel clock follows the frame position, not the look-ahead slot. The
// multiframe pulse restarts its down-counter at each multiframe entry.
module tsf_sync_gen
    import tsf_pkg::*;
#(
    parameter int CH_BITS  = 8,
    parameter int MF_PULSE = 65,
    parameter int POS_W    = 9,
    parameter int CNT_W    = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sys_rate,
    input  logic [POS_W-1:0] nxt_pos,
    input  logic             mf_entry,
    output logic             chan_clk,
    output logic             mf_sync
);
    localparam logic [POS_W-1:0] CHB  = POS_W'(CH_BITS);
    localparam logic [POS_W-1:0] HALF = POS_W'(CH_BITS / 2);
    localparam logic [CNT_W-1:0] PLEN = CNT_W'(MF_PULSE);

    logic [POS_W-1:0] in_ch;
    logic             cc_nxt;
    logic [CNT_W-1:0] mf_cnt;

    // Decide whether the coming bit time is in the first half of a channel.
    always_comb begin
        in_ch  = ((sys_rate == RATE_256) ? nxt_pos : nxt_pos - 1'b1) % CHB;
        cc_nxt = (in_ch < HALF) && !((sys_rate == RATE_193) && (nxt_pos == '0));
    end

    // Register the channel clock and run the multiframe pulse counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_clk <= 1'b0;
            mf_cnt   <= '0;
        end else begin
            chan_clk <= cc_nxt;
            if (mf_entry)
                mf_cnt <= PLEN;
            else if (mf_cnt != '0)
                mf_cnt <= mf_cnt - 1'b1;
        end
    end

    assign mf_sync = (mf_cnt != '0);
endmodule

// File: rtl/tsf_formatter.sv
// System-side frame timing formatter, top level.
// Assumes the rate and mode inputs are constant while out of reset, and that
// rd_byte answers rd_chan within the same cycle.
module tsf_formatter #(
    parameter int CH_BITS   = 8,
    parameter int T1_CHANS  = 24,
    parameter int E1_CHANS  = 32,
    parameter int T1_MF     = 12,
    parameter int E1_MF     = 16,
    parameter int MF_PULSE  = 65,
    parameter int LOOKAHEAD = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sys_rate,
    input  logic                        rx_rate,
    input  logic                        par_mode,
    input  logic                        fsync_in,
    input  logic [CH_BITS-1:0]          rd_byte,
    input  logic                        rx_fbit,
    output logic [$clog2(E1_CHANS)-1:0] rd_chan,
    output logic                        ser_out,
    output logic                        chan_clk,
    output logic                        mf_sync
);
    localparam int T1_LEN = T1_CHANS * CH_BITS + 1;
    localparam int E1_LEN = E1_CHANS * CH_BITS;
    localparam int POS_W  = $clog2(E1_LEN + LOOKAHEAD + 1);
    localparam int FRM_W  = $clog2(E1_MF > T1_MF ? E1_MF : T1_MF);
    localparam int CHN_W  = $clog2(E1_CHANS);
    localparam int CNT_W  = $clog2(MF_PULSE + 1);

    logic [POS_W-1:0] pos;
    logic [POS_W-1:0] nxt_pos;
    logic [FRM_W-1:0] frame;
    logic [FRM_W-1:0] nxt_frame;
    logic             mf_entry;
    logic             bit_val;

    tsf_frame_ctr #(
        .T1_LEN(T1_LEN), .E1_LEN(E1_LEN), .T1_MF(T1_MF), .E1_MF(E1_MF),
        .POS_W(POS_W), .FRM_W(FRM_W)
    ) ctr_i (
        .clk(clk), .rst_n(rst_n), .sys_rate(sys_rate), .fsync_in(fsync_in),
        .pos(pos), .frame(frame), .nxt_pos(nxt_pos), .nxt_frame(nxt_frame),
        .mf_entry(mf_entry)
    );

    tsf_slot_map #(
        .T1_LEN(T1_LEN), .E1_LEN(E1_LEN), .T1_CHANS(T1_CHANS), .CH_BITS(CH_BITS),
        .LOOKAHEAD(LOOKAHEAD), .POS_W(POS_W), .CHN_W(CHN_W)
    ) map_i (
        .slot_pos(nxt_pos), .sys_rate(sys_rate), .rx_rate(rx_rate),
        .par_mode(par_mode), .rd_byte(rd_byte), .rx_fbit(rx_fbit),
        .rd_chan(rd_chan), .bit_val(bit_val)
    );

    tsf_sync_gen #(
        .CH_BITS(CH_BITS), .MF_PULSE(MF_PULSE), .POS_W(POS_W), .CNT_W(CNT_W)
    ) sync_i (
        .clk(clk), .rst_n(rst_n), .sys_rate(sys_rate), .nxt_pos(nxt_pos),
        .mf_entry(mf_entry), .chan_clk(chan_clk), .mf_sync(mf_sync)
    );

    // Load the serial output with the bit chosen for the coming position.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ser_out <= 1'b1;
        else
            ser_out <= bit_val;
    end
endmodule

// File: rtl/tsf_formatter_chk.sv
// Property checker for tsf_formatter, attached by bind.
// Watches the frame position and count next to the output pins.
module tsf_formatter_chk #(
    parameter int POS_W    = 9,
    parameter int FRM_W    = 4,
    parameter int T1_CHANS = 24,
    parameter int CH_BITS  = 8,
    parameter int E1_CHANS = 32,
    parameter int MF_PULSE = 65
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sys_rate,
    input logic             rx_rate,
    input logic             par_mode,
    input logic             fsync_in,
    input logic             ser_out,
    input logic             chan_clk,
    input logic             mf_sync,
    input logic [POS_W-1:0] pos,
    input logic [FRM_W-1:0] frame
);
    localparam int CNT_W = $clog2(MF_PULSE + 2);
    localparam logic [POS_W-1:0] FILL_AT = POS_W'(T1_CHANS * CH_BITS);
    localparam logic [POS_W-1:0] FLEN_T1 = POS_W'(T1_CHANS * CH_BITS + 1);
    localparam logic [POS_W-1:0] FLEN_E1 = POS_W'(E1_CHANS * CH_BITS);
    localparam logic [CNT_W-1:0] PLEN    = CNT_W'(MF_PULSE);

    logic [CNT_W-1:0] hi_run;

    // Count consecutive cycles with the multiframe pulse high.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hi_run <= '0;
        else if (mf_sync && hi_run <= PLEN)
            hi_run <= hi_run + 1'b1;
        else if (!mf_sync)
            hi_run <= '0;
    end

    assert_sync_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fsync_in) |=> (pos == '0));

    assert_pos_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pos < (sys_rate ? FLEN_E1 : FLEN_T1));

    assert_fslot_forced_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sys_rate && rx_rate && !par_mode && pos == '0) |-> ser_out);

    assert_fill_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_rate && !rx_rate && !par_mode && pos >= FILL_AT) |-> ser_out);

    assert_cc_low_fslot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!sys_rate && pos == '0) |-> !chan_clk);

    assert_mf_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mf_sync) |-> (pos == '0 && frame == '0));

    assert_mf_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mf_sync |-> (hi_run < PLEN));

    assert_mf_length_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mf_sync) |-> (hi_run == PLEN));
endmodule

bind tsf_formatter tsf_formatter_chk #(
    .POS_W(POS_W), .FRM_W(FRM_W), .T1_CHANS(T1_CHANS), .CH_BITS(CH_BITS),
    .E1_CHANS(E1_CHANS), .MF_PULSE(MF_PULSE)
) chk_i (
    .clk(clk), .rst_n(rst_n), .sys_rate(sys_rate), .rx_rate(rx_rate),
    .par_mode(par_mode), .fsync_in(fsync_in), .ser_out(ser_out),
    .chan_clk(chan_clk), .mf_sync(mf_sync), .pos(pos), .frame(frame)
);

// File: tb/tsf_formatter_tb.sv
// Bench for tsf_formatter: a behavioural model stepped on every rising edge,
// compared with the pins on every falling edge.
module tsf_formatter_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sys_rate = 1'b0;
    logic       rx_rate = 1'b0;
    logic       par_mode = 1'b0;
    logic       fsync_in = 1'b0;
    logic       rx_fbit = 1'b0;
    logic [7:0] salt = 8'h00;
    logic [7:0] rd_byte;
    logic [4:0] rd_chan;
    logic       ser_out;
    logic       chan_clk;
    logic       mf_sync;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    // model state
    int    m_pos = 0;
    int    m_frm = 0;
    int    m_mf  = 0;
    bit    m_ser = 1'b1;
    bit    m_cc  = 1'b0;
    bit    m_pfs = 1'b0;
    string m_tag = "R1";

    always #(CLK_PERIOD / 2) clk = ~clk;

    // store stand-in: byte of a channel derived from its number and a salt
    assign rd_byte = ({3'b000, rd_chan} * 8'd29) ^ salt;

    tsf_formatter dut_i (
        .clk(clk), .rst_n(rst_n), .sys_rate(sys_rate), .rx_rate(rx_rate),
        .par_mode(par_mode), .fsync_in(fsync_in), .rd_byte(rd_byte),
        .rx_fbit(rx_fbit), .rd_chan(rd_chan), .ser_out(ser_out),
        .chan_clk(chan_clk), .mf_sync(mf_sync)
    );

    function automatic bit pat_bit(input int ch, input int b, input logic [7:0] s);
        logic [7:0] v;
        v = (8'(ch) * 8'd29) ^ s;
        return v[b];
    endfunction

    // behavioural reference, one step per rising edge
    always @(posedge clk) begin
        int flen, mlen, look, ch, bi;
        bit rise;
        if (!rst_n) begin
            m_pos = 0; m_frm = 0; m_mf = 0; m_ser = 1'b1; m_cc = 1'b0;
            m_pfs = 1'b0; m_tag = "R1";
        end else begin
            flen = sys_rate ? 256 : 193;
            mlen = sys_rate ? 16 : 12;
            rise = fsync_in && !m_pfs;
            m_pfs = fsync_in;
            if (rise || m_pos == flen - 1) begin
                m_pos = 0;
                m_frm = (m_frm + 1) % mlen;
            end else begin
                m_pos = m_pos + 1;
            end
            if (m_pos == 0 && m_frm == 0) m_mf = 65;
            else if (m_mf > 0) m_mf = m_mf - 1;
            if (!sys_rate) m_cc = (m_pos != 0) && (((m_pos - 1) % 8) < 4);
            else           m_cc = (m_pos % 8) < 4;
            look = (m_pos + (par_mode ? 8 : 0)) % flen;
            if (!sys_rate && look == 0) begin
                m_ser = rx_rate ? 1'b1 : rx_fbit;
                m_tag = rx_rate ? "R6" : "R5";
            end else begin
                ch = sys_rate ? look / 8 : (look - 1) / 8;
                bi = sys_rate ? 7 - (look % 8) : 7 - ((look - 1) % 8);
                if (sys_rate && !rx_rate && ch >= 24) begin
                    m_ser = 1'b1;
                    m_tag = "R7";
                end else begin
                    m_ser = pat_bit(ch, bi, salt);
                    m_tag = par_mode ? "R8" : (sys_rate ? "R4" : "R3");
                end
            end
            if (rise) m_tag = "R2";
        end
    end

    task automatic check_bit(input string tag, input logic act, input logic exp, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s cycle %0d: actual=%0b expected=%0b", tag, what, cyc, act, exp);
        end
    endtask

    // compare every output with the model, at the falling edge
    task automatic compare_all();
        check_bit(m_tag, ser_out, m_ser, "ser_out");
        check_bit("R10", chan_clk, m_cc, "chan_clk");
        check_bit("R9", mf_sync, m_mf > 0, "mf_sync");
    endtask

    task automatic run_case(input logic s, input logic r, input logic p,
                            input logic [7:0] sv, input int resync_at, input int ncyc);
        @(negedge clk);
        rst_n = 1'b0; fsync_in = 1'b0;
        sys_rate = s; rx_rate = r; par_mode = p; salt = sv;
        repeat (3) @(negedge clk);
        // reset state, R1
        check_bit("R1", ser_out, 1'b1, "ser_out in reset");
        check_bit("R1", chan_clk, 1'b0, "chan_clk in reset");
        check_bit("R1", mf_sync, 1'b0, "mf_sync in reset");
        rst_n = 1'b1;
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            cyc = i;
            compare_all();
            fsync_in = (i >= 20 && i < 23) ||
                       (resync_at > 0 && i >= resync_at && i < resync_at + 3);
            rx_fbit = i[3] ^ i[0] ^ i[6];
        end
    endtask

    initial begin
        // serial, all rate pairs: F pass-through R5, forced F R6, fill R7, plain R4
        run_case(1'b0, 1'b0, 1'b0, 8'h5A, 1111, 5000);
        run_case(1'b0, 1'b1, 1'b0, 8'hC3, 0,    5000);
        run_case(1'b1, 1'b0, 1'b0, 8'h00, 777,  5000);
        run_case(1'b1, 1'b1, 1'b0, 8'h96, 0,    5000);
        // parallel look-ahead, R8, with a mid-frame resync (R2)
        run_case(1'b0, 1'b0, 1'b1, 8'h3C, 905,  5000);
        run_case(1'b1, 1'b0, 1'b1, 8'hA5, 0,    5000);
        run_case(1'b0, 1'b1, 1'b1, 8'h0F, 0,    5000);
        run_case(1'b1, 1'b1, 1'b1, 8'hE1, 1300, 5000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        total++;
        bad++;
        $display("FAIL watchdog: run did not complete");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule